// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C target that lets a host controller read and write a bank of sixteen 8-bit registers over the two-wire serial bus. Both bus lines enter through a two-stage synchroniser, and all protocol logic runs on a single fast system clock. Each line is modelled as open-drain, with an input and a separate active-high pull-low enable. The target answers only to the fixed 7-bit address 1101000.

A write transfer works as follows. The host sends the address byte with the direction bit clear. The next byte sets the internal register pointer. Every byte after that is stored at the pointer, and the pointer then steps forward. A read transfer, usually reached through a repeated START after the pointer has been set, returns bytes starting at the pointer. The target keeps sending while the host acknowledges and stops driving after a not-acknowledge. The pointer steps through sixteen locations and wraps from 0Fh to 00h.

The controller is a single state machine. Its states are:
- `ST_IDLE`: waiting for a START.
- `ST_ADDR`: receiving the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_PTR`: receiving the pointer byte.
- `ST_PTR_ACK`: acknowledging the pointer byte.
- `ST_WR`: receiving a data byte.
- `ST_WR_ACK`: acknowledging a data byte.
- `ST_RD`: shifting a byte out.
- `ST_RD_ACK`: sampling the host's acknowledge.
- `ST_WAIT`: ignoring the bus.

Its transitions are:
- START, from any state, goes to `ST_ADDR`. STOP, from any state, goes to `ST_IDLE`.
- From `ST_ADDR`, after the eighth bit and the following SCL fall, a matching address goes to `ST_ADDR_ACK` and any other address goes to `ST_WAIT`.
- `ST_ADDR_ACK` goes to `ST_RD` when the direction bit is 1 and to `ST_PTR` when it is 0.
- `ST_PTR` goes to `ST_PTR_ACK`, which goes to `ST_WR`.
- `ST_WR` goes to `ST_WR_ACK`, which returns to `ST_WR`.
- `ST_RD` goes to `ST_RD_ACK` after its eighth bit.
- `ST_RD_ACK` goes back to `ST_RD` on a host acknowledge, or to `ST_WAIT` on a not-acknowledge.

Top module: `i2c_regbank_target`

## Requirements
- R1: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) abandons any partly received byte without storing it. START restarts address reception; STOP returns to idle.
- R2: The address byte is the first byte after a START. Its bits 7..1 are the address and bit 0 is the direction (1 = read, 0 = write). When bits 7..1 equal 1101000, the target pulls SDA low for the whole high phase of the ninth SCL pulse.
- R3: Any other address gets no acknowledge. SDA is then left released, and no register or pointer changes, until the next START.
- R4: In a write, the first byte after the address is acknowledged and its low four bits load the register pointer; its upper four bits are discarded.
- R5: Each further write byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R6: The pointer wraps from 0Fh to 00h, both when writing and when reading.
- R7: A read sends the register at the pointer, MSB first. The target changes what it drives on SDA only while SCL is low.
- R8: When the host acknowledges a read byte, the next byte comes from pointer+1. When the host does not acknowledge, the target releases SDA and stays released until a START or STOP.
- R9: After reset, SDA is released, all registers read 00h and the pointer is 0.
- R10: The SCL pull-low enable is never asserted; the target never holds the clock low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level sensed on the serial clock line |
| sda_i | input | 1 | Level sensed on the serial data line |
| scl_oe | output | 1 | Pull-low enable for the clock line (held 0) |
| sda_oe | output | 1 | Pull-low enable for the data line |

## Verification
An edge on `scl_i` takes three system clocks to reach `sda_oe`: two for the synchroniser and one for the state register. Register writes and pointer steps land in that same cycle. The bench waits ten clocks after every SCL edge before it raises SCL again. During each SCL high phase it compares `sda_oe` against the model's expected drive on every clock, so an acknowledge or data bit that arrives late, or drops out partway through the high phase, is caught. Read bytes and acknowledge levels are sampled in the middle of the high phase, well clear of that three-cycle latency.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_WAIT
    } tgt_state_e;

    // one-cycle bus events after synchronisation
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 scl_lvl,
    output i2c_rb_pkg::bus_ev_t  ev
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_ff[g] <= scl_i;
                    sda_ff[g] <= sda_i;
                end else begin
                    scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
                    sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_ff[STAGES-1];
            sda_q <= sda_ff[STAGES-1];
        end
    end

    assign scl_lvl     = scl_ff[STAGES-1];
    assign ev.sda      = sda_ff[STAGES-1];
    assign ev.scl_rise = scl_ff[STAGES-1] & ~scl_q;
    assign ev.scl_fall = ~scl_ff[STAGES-1] & scl_q;
    assign ev.start    = scl_ff[STAGES-1] & scl_q & sda_q & ~sda_ff[STAGES-1];
    assign ev.stop     = scl_ff[STAGES-1] & scl_q & ~sda_q & sda_ff[STAGES-1];

endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
    parameter int NREG = 16,
    parameter int DW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] addr,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata
);
    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/i2c_rb_ctrl.sv
module i2c_rb_ctrl
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101000,
    parameter int         NREG     = 16,
    parameter int         DW       = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  bus_ev_t                 ev,
    input  logic [DW-1:0]           rd_data,
    output logic [$clog2(NREG)-1:0] reg_ptr,
    output logic                    wr_en,
    output logic [DW-1:0]           wr_data,
    output logic                    sda_oe
);
    localparam int PW = $clog2(NREG);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW-1);

    tgt_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic          done;
    logic [DW-1:0] shreg;
    logic [DW-1:0] tx;
    logic          rw;
    logic          hack;
    logic [PW-1:0] ptr;
    logic          addr_hit;

    assign addr_hit = (shreg[DW-1 -: 7] == DEV_ADDR);
    assign reg_ptr  = ptr;
    assign wr_data  = shreg;
    assign wr_en    = (state == ST_WR) && ev.scl_fall && done && !ev.start && !ev.stop;

    // next-state logic
    always_comb begin
        nxt = state;
        if (ev.start) begin
            nxt = ST_ADDR;
        end else if (ev.stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (ev.scl_fall && done) nxt = addr_hit ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK: if (ev.scl_fall) nxt = rw ? ST_RD : ST_PTR;
                ST_PTR:      if (ev.scl_fall && done) nxt = ST_PTR_ACK;
                ST_PTR_ACK:  if (ev.scl_fall) nxt = ST_WR;
                ST_WR:       if (ev.scl_fall && done) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (ev.scl_fall) nxt = ST_WR;
                ST_RD:       if (ev.scl_fall && cnt == LAST_BIT) nxt = ST_RD_ACK;
                ST_RD_ACK: begin
                    if (ev.scl_rise && ev.sda)       nxt = ST_WAIT;
                    else if (ev.scl_fall && hack)    nxt = ST_RD;
                end
                ST_WAIT:     nxt = ST_WAIT;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            done  <= 1'b0;
            shreg <= '0;
            tx    <= '0;
            rw    <= 1'b0;
            hack  <= 1'b0;
            ptr   <= '0;
        end else if (ev.start || ev.stop) begin
            cnt  <= '0;
            done <= 1'b0;
            hack <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WR: begin
                    if (ev.scl_rise) begin
                        shreg <= {shreg[DW-2:0], ev.sda};
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_BIT) done <= 1'b1;
                    end
                    if (ev.scl_fall && done) begin
                        done <= 1'b0;
                        cnt  <= '0;
                        if (state == ST_ADDR) rw  <= shreg[0];
                        if (state == ST_PTR)  ptr <= shreg[PW-1:0];
                        if (state == ST_WR)   ptr <= ptr + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.scl_fall && rw) begin
                        tx  <= rd_data;
                        cnt <= '0;
                    end
                end
                ST_RD: begin
                    hack <= 1'b0;
                    if (ev.scl_fall) begin
                        tx  <= tx << 1;
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RD_ACK: begin
                    if (ev.scl_rise && !ev.sda) begin
                        hack <= 1'b1;
                        ptr  <= ptr + 1'b1;
                    end
                    if (ev.scl_fall && hack) begin
                        tx   <= rd_data;
                        cnt  <= '0;
                        hack <= 1'b0;
                    end
                end
                default: begin
                    cnt  <= cnt;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD:                              sda_oe = ~tx[DW-1];
            default:                            sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
    parameter logic [6:0] DEV_ADDR    = 7'b1101000,
    parameter int         NREG        = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe,
    output logic sda_oe
);
    localparam int DW = 8;
    localparam int PW = $clog2(NREG);

    i2c_rb_pkg::bus_ev_t ev;
    logic                scl_lvl;
    logic [PW-1:0]       reg_ptr;
    logic                wr_en;
    logic [DW-1:0]       wr_data;
    logic [DW-1:0]       rd_data;

    i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_lvl (scl_lvl),
        .ev      (ev)
    );

    i2c_rb_ctrl #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .DW(DW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .rd_data (rd_data),
        .reg_ptr (reg_ptr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

    i2c_rb_regs #(.NREG(NREG), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .addr  (reg_ptr),
        .wdata (wr_data),
        .rdata (rd_data)
    );

    assign scl_oe = 1'b0;

endmodule

// File: rtl/i2c_rb_checker.sv
module i2c_rb_checker #(
    parameter int PW = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_lvl,
    input i2c_rb_pkg::bus_ev_t ev,
    input logic                sda_oe,
    input logic                wr_en,
    input logic [PW-1:0]       ptr
);
    localparam logic [PW-1:0] ONE = PW'(1);

    // R7: data line drive changes only while the synchronised clock is low
    a_r7_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_oe) |-> !scl_lvl);

    // R1: a START leaves the data line released
    a_r1_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        ev.start |=> !sda_oe);

    // R1: a STOP leaves the data line released
    a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stop |=> !sda_oe);

    // R5 / R6: each stored byte steps the pointer by one, modulo the bank size
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ptr == PW'($past(ptr) + ONE));

endmodule

bind i2c_regbank_target i2c_rb_checker #(.PW(PW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_lvl (scl_lvl),
    .ev      (ev),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .ptr     (reg_ptr)
);

// File: tb/i2c_regbank_target_test.sv
`timescale 1ns/1ps
module i2c_regbank_target_test;

    localparam int HALF = 10;
    localparam logic [7:0] AW = 8'hD0;  // address 1101000, write
    localparam logic [7:0] AR = 8'hD1;  // address 1101000, read

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic scl_oe, sda_oe;
    wire  sda_line = sda_h & ~sda_oe;

    always #2 clk = ~clk;  // 250 MHz

    i2c_regbank_target uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_h),
        .sda_i  (sda_line),
        .scl_oe (scl_oe),
        .sda_oe (sda_oe)
    );

    int   n_chk = 0;
    int   n_err = 0;
    int   mem [16];
    int   mptr = 0;
    logic exp_valid = 1'b0;
    logic exp_oe = 1'b0;
    logic bad = 1'b0;

    // per-clock comparison against the model's expected drive
    always begin
        @(negedge clk);
        #1;
        if (exp_valid && (sda_oe !== exp_oe)) bad = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, input logic eoe, output logic seen);
        sda_h = b;
        half_wait();
        scl_h = 1'b1; exp_oe = eoe; exp_valid = 1'b1;
        half_wait();
        seen = sda_line;
        half_wait();
        exp_valid = 1'b0; scl_h = 1'b0;
        half_wait();
    endtask

    task automatic start_c();   // START or repeated START, ends with SCL low
        sda_h = 1'b1; half_wait();
        scl_h = 1'b1; half_wait();
        sda_h = 1'b0; half_wait();
        scl_h = 1'b0; half_wait();
    endtask

    task automatic stop_c();
        sda_h = 1'b0; half_wait();
        scl_h = 1'b1; half_wait();
        sda_h = 1'b1; half_wait();
    endtask

    task automatic write_byte(input logic [7:0] d, input logic ack_exp, input string tag);
        logic s;
        bad = 1'b0;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], 1'b0, s);
        clk_bit(1'b1, ack_exp, s);
        chk(!bad && (s == !ack_exp), tag, s, !ack_exp);
    endtask

    task automatic read_byte(input logic [7:0] e, input logic host_ack, input string tag);
        logic [7:0] got;
        logic s;
        bad = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, ~e[i], s);
            got[i] = s;
        end
        clk_bit(!host_ack, 1'b0, s);
        chk(!bad && (got == e), tag, got, e);
    endtask

    task automatic rd_bytes(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            read_byte(8'(mem[mptr]), k != n-1, tag);
            if (k != n-1) mptr = (mptr + 1) % 16;
        end
    endtask

    task automatic set_ptr(input logic [7:0] p);
        start_c();
        write_byte(AW, 1'b1, "R2 write address");
        write_byte(p, 1'b1, "R4 pointer byte");
        mptr = p % 16;
    endtask

    task automatic wr_xfer(input logic [7:0] p, input logic [7:0] d [$], input string tag);
        set_ptr(p);
        foreach (d[k]) begin
            write_byte(d[k], 1'b1, tag);
            mem[mptr] = d[k];
            mptr = (mptr + 1) % 16;
        end
        stop_c();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic s;
        for (int i = 0; i < 16; i++) mem[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R9 sda released after reset", sda_oe, 0);
        chk(scl_oe == 1'b0, "R10 scl never driven", scl_oe, 0);

        // R9: registers zero and pointer zero
        start_c();
        write_byte(AR, 1'b1, "R2 read address");
        rd_bytes(2, "R9 reset contents");
        stop_c();

        // R5: multi-byte write, then read continuing from pointer
        wr_xfer(8'h03, '{8'hA5, 8'h5A}, "R5 data byte ack");
        start_c();
        write_byte(AR, 1'b1, "R2 read address");
        rd_bytes(2, "R8 read from current pointer");
        stop_c();

        // R7: pointer set then repeated START read
        set_ptr(8'h03);
        start_c();
        write_byte(AR, 1'b1, "R2 read address");
        rd_bytes(3, "R7 read MSB first");
        stop_c();

        // R6: wrap on writes and on reads
        wr_xfer(8'h0E, '{8'h11, 8'h22, 8'h33}, "R6 write across wrap");
        set_ptr(8'h0F);
        start_c();
        write_byte(AR, 1'b1, "R2 read address");
        rd_bytes(3, "R6 read across wrap");
        repeat (2*HALF) @(negedge clk);
        chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
        stop_c();

        // R4: upper pointer bits discarded
        wr_xfer(8'h12, '{8'h77}, "R4 write via 12h");
        set_ptr(8'h02);
        start_c();
        write_byte(AR, 1'b1, "R2 read address");
        rd_bytes(1, "R4 low nibble pointer");
        stop_c();

        // R3: foreign addresses ignored
        start_c();
        write_byte(8'hA0, 1'b0, "R3 no ack foreign write");
        write_byte(8'h02, 1'b0, "R3 ignored byte");
        write_byte(8'h00, 1'b0, "R3 ignored byte");
        stop_c();
        start_c();
        write_byte(8'hD3, 1'b0, "R3 no ack foreign read");
        write_byte(8'hFF, 1'b0, "R3 no drive");
        stop_c();
        set_ptr(8'h02);
        start_c();
        write_byte(AR, 1'b1, "R2 read address");
        rd_bytes(1, "R3 register unchanged");
        stop_c();

        // R1: STOP in the middle of a data byte
        set_ptr(8'h05);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, 1'b0, s);
        stop_c();
        start_c();
        write_byte(AR, 1'b1, "R2 read address");
        rd_bytes(1, "R1 stop aborts byte");
        stop_c();

        // R1: repeated START in the middle of a data byte
        set_ptr(8'h06);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, 1'b0, s);
        start_c();
        write_byte(AR, 1'b1, "R2 read address");
        rd_bytes(1, "R1 start aborts byte");
        stop_c();

        repeat (4*HALF) @(negedge clk);
        chk(scl_oe == 1'b0, "R10 scl never driven", scl_oe, 0);
        chk(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule